// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This unit holds the status word, the configuration word and the debug-state word of an SD host controller. It also drives the host's single interrupt line. It watches the remaining transfer byte count and the flags of the command in progress. Whenever that count is zero it treats the transfer as finished. It then raises the completion flag and whichever interrupt causes the configuration enables and the command qualifies.

Error detectors elsewhere in the host report events as one-cycle pulses, and each pulse latches into its own status bit. Software acknowledges events by writing ones to the status word. Completion is evaluated again on every cycle in which the count stays at zero. A clear issued while the count is still zero therefore loses to the set, and the bit remains 1. The debug word carries a four-bit state code in bits 3:0 and a copy of the FIFO fill level in bits 8:4.

Top module: `sdh_status_top`

## Requirements
- R1: `irq_o` is 1 exactly when at least one of status bits 10 (busy), 9 (block) or 8 (data) is 1.
- R2: A status write (`sts_wr_en`) clears each status bit whose `wr_data` bit is 1 and leaves every other bit unchanged. Set bits stay set until they are cleared this way.
- R3: In any cycle where `byte_cnt` is zero, status bit 0 is set at the next clock edge. Bit 8 is set at the same edge if configuration bit 4 is 1.
- R4: On completion, status bit 10 is set only when `cmd_word` bit 11 (busy-wait) and configuration bit 10 are both 1.
- R5: On completion, status bit 9 is set only when `cmd_word` bit 7 (write) and configuration bit 8 are both 1.
- R6: A one-cycle pulse on `err_pulse[k]` sets status bit 3+k at the next edge. The bits are: 7 data timeout, 6 command timeout, 5 CRC16 error, 4 CRC7 error, 3 FIFO error.
- R7: On completion, debug bits 3:0 become 1 (data mode). With a nonzero byte count they hold their value.
- R8: Debug bits 8:4 equal the `fifo_level` sampled at the previous clock edge. Software writes cannot change them.
- R9: A debug write (`dbg_wr_en`) stores `wr_data` outside bits 8:4. If `wr_data[3:0]` is 0xF, it stores 0 in bits 3:0.
- R10: After reset the status word is 0, the configuration word is 0 and the debug word is 0x0000C60F.
- R11: In the same cycle, a set from completion or an error pulse wins over a software clear of that bit. Status bits 2 and 1 always read 0.
- R12: A configuration write (`cfg_wr_en`) stores `wr_data[10:0]` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 32 | Write data shared by the three register writes |
| sts_wr_en | input | 1 | Write-one-to-clear strobe for the status word |
| cfg_wr_en | input | 1 | Load strobe for the configuration word |
| dbg_wr_en | input | 1 | Load strobe for the debug word |
| byte_cnt | input | 16 | Remaining transfer byte count |
| cmd_word | input | 16 | Current command flags |
| fifo_level | input | 5 | Current FIFO fill level |
| err_pulse | input | 5 | Error event pulses for status bits 7:3 |
| status_o | output | 11 | Status word |
| cfg_o | output | 11 | Configuration word |
| dbg_o | output | 32 | Debug word |
| irq_o | output | 1 | Interrupt request |

## Verification
The interrupt causes depend on three configuration enables and two command flags together, and only a completion event with those settings at that moment reveals them. The bench therefore sweeps all 32 combinations. For each one it:
- writes the configuration,
- clears the status word while the byte count is nonzero,
- drops the count to zero for exactly one cycle,
- checks the latched cause bits and the interrupt on the following cycle and again one cycle later.

The race between a software clear and a completion that is still active is created by writing the clear in the very cycle the count is zero.

// File: rtl/sdh_status_pkg.sv
// Package: bit positions and widths shared by the status unit.
// Assumes the status and configuration field positions are fixed by the
// software view; only counter and debug widths are free to change.
package sdh_status_pkg;
    localparam int STS_W      = 11;
    localparam int CFG_W      = 11;
    localparam int ERR_W      = 5;

    localparam int STS_DONE   = 0;
    localparam int STS_ERR_LO = 3;
    localparam int STS_DATA   = 8;
    localparam int STS_BLOCK  = 9;
    localparam int STS_BUSY   = 10;

    localparam int CFG_DATA_EN  = 4;
    localparam int CFG_BLOCK_EN = 8;
    localparam int CFG_BUSY_EN  = 10;

    localparam int CMD_WRITE  = 7;
    localparam int CMD_BUSYW  = 11;

    localparam logic [STS_W-1:0] STS_VALID = 11'b111_1111_1001;

    localparam logic [3:0] DBG_STATE_DATA = 4'h1;
    localparam logic [3:0] DBG_STATE_OFF  = 4'hF;
endpackage

// File: rtl/sdh_cause_gen.sv
// Module: sdh_cause_gen
// Combines the completion condition, command flags, configuration enables
// and error pulses into a vector of status bits to set this cycle.
// Assumes byte count equal to zero means the transfer is complete.
module sdh_cause_gen
    import sdh_status_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CMD_W = 16
) (
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic [CFG_W-1:0] cfg,
    input  logic [ERR_W-1:0] err_pulse,
    output logic             done,
    output logic [STS_W-1:0] set_vec
);
    // Completion detect.
    assign done = (byte_cnt == '0);

    // Build the per-bit set request.
    always_comb begin
        set_vec = '0;
        set_vec[STS_DONE]  = done;
        set_vec[STS_DATA]  = done & cfg[CFG_DATA_EN];
        set_vec[STS_BLOCK] = done & cmd_word[CMD_WRITE] & cfg[CFG_BLOCK_EN];
        set_vec[STS_BUSY]  = done & cmd_word[CMD_BUSYW] & cfg[CFG_BUSY_EN];
        for (int k = 0; k < ERR_W; k++) begin
            set_vec[STS_ERR_LO+k] = err_pulse[k];
        end
    end
endmodule

// File: rtl/sdh_status_reg.sv
// Module: sdh_status_reg
// Sticky status word with write-one-to-clear; sets win over clears.
// Drives the interrupt from the three interrupt cause bits.
module sdh_status_reg
    import sdh_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [STS_W-1:0] clr_vec,
    input  logic [STS_W-1:0] set_vec,
    output logic [STS_W-1:0] status,
    output logic             irq
);
    logic [STS_W-1:0] clr_mask;

    // Select clear mask only on a status write.
    assign clr_mask = clr_en ? clr_vec : '0;

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr_mask) | set_vec) & STS_VALID;
    end

    // Interrupt from busy, block and data causes.
    assign irq = status[STS_BUSY] | status[STS_BLOCK] | status[STS_DATA];
endmodule

// File: rtl/sdh_dbg_reg.sv
// Module: sdh_dbg_reg
// Debug word: software-writable, with a state code forced to data mode on
// completion and a FIFO-level field refreshed every cycle.
// Assumes DBG_W is at least 9 so the level field fits.
module sdh_dbg_reg
    import sdh_status_pkg::*;
#(
    parameter int              DBG_W   = 32,
    parameter int              LVL_W   = 5,
    parameter logic [DBG_W-1:0] DBG_RST = 32'h0000_C60F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DBG_W-1:0] wr_val,
    input  logic             done,
    input  logic [LVL_W-1:0] fifo_level,
    output logic [DBG_W-1:0] dbg
);
    localparam int LVL_LO = 4;
    localparam int LVL_HI = LVL_LO + LVL_W - 1;

    logic [DBG_W-1:0] dbg_nxt;

    // Next-value selection: write, then completion, then level refresh.
    always_comb begin
        dbg_nxt = dbg;
        if (wr_en) begin
            dbg_nxt = wr_val;
            if (wr_val[3:0] == DBG_STATE_OFF) dbg_nxt[3:0] = 4'h0;
        end
        if (done) dbg_nxt[3:0] = DBG_STATE_DATA;
        dbg_nxt[LVL_HI:LVL_LO] = fifo_level;
    end

    // Debug register.
    always_ff @(posedge clk) begin
        if (!rst_n) dbg <= DBG_RST;
        else        dbg <= dbg_nxt;
    end
endmodule

// File: rtl/sdh_status_top.sv
// Module: sdh_status_top
// Status, configuration and debug registers plus interrupt output of an
// SD host. Assumes byte count, command flags and FIFO level come from the
// transfer engine and error pulses last one cycle each.
module sdh_status_top
    import sdh_status_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CMD_W = 16,
    parameter int LVL_W = 5,
    parameter int DBG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      wr_data,
    input  logic             sts_wr_en,
    input  logic             cfg_wr_en,
    input  logic             dbg_wr_en,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [ERR_W-1:0] err_pulse,
    output logic [STS_W-1:0] status_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [DBG_W-1:0] dbg_o,
    output logic             irq_o
);
    logic             done;
    logic [STS_W-1:0] set_vec;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_o <= '0;
        else if (cfg_wr_en) cfg_o <= wr_data[CFG_W-1:0];
    end

    sdh_cause_gen #(.CNT_W(CNT_W), .CMD_W(CMD_W)) cause_i (
        .byte_cnt (byte_cnt),
        .cmd_word (cmd_word),
        .cfg      (cfg_o),
        .err_pulse(err_pulse),
        .done     (done),
        .set_vec  (set_vec)
    );

    sdh_status_reg sts_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_en (sts_wr_en),
        .clr_vec(wr_data[STS_W-1:0]),
        .set_vec(set_vec),
        .status (status_o),
        .irq    (irq_o)
    );

    sdh_dbg_reg #(.DBG_W(DBG_W), .LVL_W(LVL_W)) dbg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dbg_wr_en),
        .wr_val    (wr_data[DBG_W-1:0]),
        .done      (done),
        .fifo_level(fifo_level),
        .dbg       (dbg_o)
    );
endmodule

// File: rtl/sdh_status_chk.sv
// Module: sdh_status_chk
// Checker bound to sdh_status_top; relates its ports over time.
module sdh_status_chk
    import sdh_status_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CMD_W = 16,
    parameter int LVL_W = 5,
    parameter int DBG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [CMD_W-1:0] cmd_word,
    input logic [LVL_W-1:0] fifo_level,
    input logic [ERR_W-1:0] err_pulse,
    input logic [STS_W-1:0] status_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic [DBG_W-1:0] dbg_o,
    input logic             irq_o
);
    // R1
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_o[10:8] != 3'b000));
    // R3
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == '0) |=> status_o[STS_DONE]);
    // R3
    data_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == '0 && cfg_o[CFG_DATA_EN]) |=> status_o[STS_DATA]);
    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[STS_BUSY]) |->
            $past(byte_cnt == '0 && cmd_word[CMD_BUSYW] && cfg_o[CFG_BUSY_EN]));
    // R5
    block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[STS_BLOCK]) |->
            $past(byte_cnt == '0 && cmd_word[CMD_WRITE] && cfg_o[CFG_BLOCK_EN]));
    // R6
    err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse != '0) |=>
            ((status_o[7:3] & $past(err_pulse)) == $past(err_pulse)));
    // R7
    dbg_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == '0) |=> (dbg_o[3:0] == DBG_STATE_DATA));
    // R8
    dbg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dbg_o[LVL_W+3:4] == $past(fifo_level)));
    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2:1] == 2'b00);
endmodule

bind sdh_status_top sdh_status_chk #(
    .CNT_W(CNT_W), .CMD_W(CMD_W), .LVL_W(LVL_W), .DBG_W(DBG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_cnt  (byte_cnt),
    .cmd_word  (cmd_word),
    .fifo_level(fifo_level),
    .err_pulse (err_pulse),
    .status_o  (status_o),
    .cfg_o     (cfg_o),
    .dbg_o     (dbg_o),
    .irq_o     (irq_o)
);

// File: tb/sdh_status_top_tb_top.sv
// Bench: sweeps cause/enable combinations, error bits, FIFO levels and
// debug writes; inputs change on the falling edge and are sampled there.
module sdh_status_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sts_wr_en = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        dbg_wr_en = 1'b0;
    logic [15:0] byte_cnt = 16'd5;
    logic [15:0] cmd_word = '0;
    logic [4:0]  fifo_level = '0;
    logic [4:0]  err_pulse = '0;
    logic [10:0] status_o;
    logic [10:0] cfg_o;
    logic [31:0] dbg_o;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    sdh_status_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .sts_wr_en(sts_wr_en), .cfg_wr_en(cfg_wr_en), .dbg_wr_en(dbg_wr_en),
        .byte_cnt(byte_cnt), .cmd_word(cmd_word), .fifo_level(fifo_level),
        .err_pulse(err_pulse), .status_o(status_o), .cfg_o(cfg_o),
        .dbg_o(dbg_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        sts_wr_en = 1'b1; wr_data = 32'h0000_07FF;
        tick();
        sts_wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        logic [10:0] exp_sts;
        logic [31:0] exp_dbg;
        tick(); tick();
        // R10 reset values while reset is held
        check("R10 status", {21'd0, status_o}, 32'd0);
        check("R10 config", {21'd0, cfg_o}, 32'd0);
        check("R10 debug", dbg_o, 32'h0000_C60F);
        check("R1 irq at reset", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;
        tick();
        // R7 no completion: state code holds
        check("R7 debug held", dbg_o, 32'h0000_C60F);
        check("R10 status after release", {21'd0, status_o}, 32'd0);

        // R3 R4 R5 R1 R12 sweep of all flag/enable combinations
        for (int i = 0; i < 32; i++) begin
            logic bw, wrf, c4, c8, c10;
            logic [31:0] cfgv;
            bw = i[0]; wrf = i[1]; c4 = i[2]; c8 = i[3]; c10 = i[4];
            cfgv = (32'(c4) << 4) | (32'(c8) << 8) | (32'(c10) << 10) | 32'h8;
            cmd_word = (16'(bw) << 11) | (16'(wrf) << 7);
            cfg_wr_en = 1'b1; wr_data = cfgv;
            tick();
            cfg_wr_en = 1'b0;
            check("R12 config stored", {21'd0, cfg_o}, cfgv);
            clear_all();
            check("R2 cleared", {21'd0, status_o}, 32'd0);
            check("R1 irq low", {31'd0, irq_o}, 32'd0);
            byte_cnt = 16'd0;
            tick();
            byte_cnt = 16'd7;
            exp_sts = 11'h001 | (11'(c4) << 8) | (11'(wrf & c8) << 9) | (11'(bw & c10) << 10);
            check("R3 R4 R5 causes", {21'd0, status_o}, {21'd0, exp_sts});
            check("R1 irq", {31'd0, irq_o}, {31'd0, |exp_sts[10:8]});
            check("R7 state code", {28'd0, dbg_o[3:0]}, 32'd1);
            tick();
            check("R2 sticky", {21'd0, status_o}, {21'd0, exp_sts});
        end
        cmd_word = '0;

        // R6 error pulses, one bit at a time, then W1C of that bit
        for (int k = 0; k < 5; k++) begin
            clear_all();
            err_pulse = 5'(1 << k);
            tick();
            err_pulse = '0;
            check("R6 error latched", {21'd0, status_o}, 32'(1 << (3 + k)));
            tick();
            check("R6 error sticky", {21'd0, status_o}, 32'(1 << (3 + k)));
        end

        // R2 partial clear leaves other bits
        clear_all();
        err_pulse = 5'b11111;
        tick();
        err_pulse = '0;
        sts_wr_en = 1'b1; wr_data = 32'h0000_0050;
        tick();
        sts_wr_en = 1'b0;
        check("R2 partial clear", {21'd0, status_o}, 32'h0000_00A8);

        // R11 set wins over same-cycle clear; reserved bits zero
        clear_all();
        byte_cnt = 16'd0; sts_wr_en = 1'b1; wr_data = 32'h0000_07FF;
        err_pulse = 5'b00001;
        tick();
        sts_wr_en = 1'b0; byte_cnt = 16'd3; err_pulse = '0;
        check("R11 set wins", {21'd0, status_o & 11'h009}, 32'h0000_0009);
        check("R11 reserved zero", {30'd0, status_o[2:1]}, 32'd0);

        // R8 FIFO level sweep
        for (int l = 0; l < 32; l++) begin
            fifo_level = 5'(l);
            tick();
            check("R8 level field", {27'd0, dbg_o[8:4]}, 32'(l));
        end

        // R9 debug writes
        fifo_level = 5'd9;
        dbg_wr_en = 1'b1; wr_data = 32'h00A5_A0AF;
        tick();
        dbg_wr_en = 1'b0;
        exp_dbg = (32'h00A5_A0AF & ~32'h0000_01FF) | (32'd9 << 4);
        check("R9 F stored as 0", dbg_o, exp_dbg);
        dbg_wr_en = 1'b1; wr_data = 32'h1234_5FF5;
        tick();
        dbg_wr_en = 1'b0;
        exp_dbg = (32'h1234_5FF5 & ~32'h0000_01F0) | (32'd9 << 4);
        check("R9 plain write", dbg_o, exp_dbg);
        byte_cnt = 16'd0;
        tick();
        byte_cnt = 16'd3;
        check("R7 state after write", {28'd0, dbg_o[3:0]}, 32'd1);

        done_flag = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule